// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog timer on a small register bus. Four 32-bit words are mapped: a control/status word, a count word, a timeout word and a window word. The configuration is locked by default. Software opens it with a two-word key written to the count word, writes the timeout, the window and then the control word. That last write applies the configuration and closes the lock again. While running, software services the watchdog by writing a different two-word key to the count word, which sets the count back to zero.

The count advances on a tick taken from one of four sources. Source 0 ticks on every bus clock. The other three come in as single-cycle enable inputs that are sampled in the bus clock domain. A tick that arrives when the count already equals the timeout produces a one-cycle reset request and sets a sticky flag. When the window is nonzero, a service that comes too early does the same. The register bus is plain control: a write is taken in the cycle `bus_we` is high, and a read returns the addressed word combinationally. There is no back-pressure.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control/status word (byte offset 0x0) reads 0x0000_0020, the count word (0x4) reads 0, the timeout word (0x8) reads 0x0000_FFFF, the window word (0xC) reads 0, and `rst_req` is low.
- R2: Writing 0xC520 and then 0xD928 to the count word, as consecutive writes to that word, sets status bit 11 (unlocked). Any other value written between the two words discards the sequence. Writing 0xC520 again in place of the second word restarts the match.
- R3: While locked, writes to the timeout word, the window word and bits other than 14 of the control word have no effect.
- R4: Writing the control word while unlocked applies bits 7 (enable), 5 (allow re-unlock) and 9:8 (tick source), sets status bit 10 (applied), clears the count and ends the unlocked state. An unlock clears bit 10. The unlocked state also ends by itself UNLOCK_CYCLES cycles after the key.
- R5: Once bit 5 has been applied as 0, unlock keys are ignored until reset.
- R6: Bits 9:8 select the tick: 0 is every cycle, 1 is `tick_slow`, 2 is `tick_mid`, 3 is `tick_ext`. Only the selected source advances the count, and only while bit 7 is set. The count word reads the count.
- R7: A selected tick while the count equals the timeout raises `rst_req` for one cycle, in the cycle after that tick's clock edge. It also sets status bit 14 and restarts the count at 0.
- R8: Writing 0xA602 and then 0xB480 to the count word, as consecutive writes to that word, clears the count. An intervening other value discards the sequence.
- R9: With the window nonzero and the block enabled, a service whose count is below the window raises `rst_req` and bit 14 in the same way as a timeout. A service with the count at or above the window does not.
- R10: Writing 1 to bit 14 of the control word clears the flag whether locked or not. A flag set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Byte offset of the word (0x0, 0x4, 0x8, 0xC) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| tick_slow | input | 1 | Tick enable for source 1 |
| tick_mid | input | 1 | Tick enable for source 2 |
| tick_ext | input | 1 | Tick enable for source 3 |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with UNLOCK_CYCLES set to 16 and a 16-bit count. With that value the self-closing unlock can be observed within a few cycles of the key, and the same test still exercises the locked-write rule. The counting tests mostly run on source 1, so every tick is placed by the bench and each expected reset request falls in a known cycle. They include an early service against a window of 2. A short run on source 0 then shows repeated timeouts with a period of TOVAL+1 cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] OFS_CS  = 4'h0;
  localparam logic [3:0] OFS_CNT = 4'h4;
  localparam logic [3:0] OFS_TOV = 4'h8;
  localparam logic [3:0] OFS_WIN = 4'hC;

  localparam logic [31:0] OPEN_W0 = 32'h0000_C520;
  localparam logic [31:0] OPEN_W1 = 32'h0000_D928;
  localparam logic [31:0] SVC_W0  = 32'h0000_A602;
  localparam logic [31:0] SVC_W1  = 32'h0000_B480;

  localparam int B_UPD = 5;
  localparam int B_EN  = 7;
  localparam int B_SEL = 8;
  localparam int B_RCS = 10;
  localparam int B_ULK = 11;
  localparam int B_FLG = 14;

  typedef enum logic [1:0] {SRC_BUS, SRC_SLOW, SRC_MID, SRC_EXT} src_e;
endpackage

// File: rtl/wdt_key_match.sv
module wdt_key_match #(
  parameter logic [31:0] FIRST  = 32'h0,
  parameter logic [31:0] SECOND = 32'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        hit
);
  logic armed;

  assign hit = wr && armed && (wdata == SECOND);

  // every write to the word re-evaluates: only the first word keeps it armed
  always_ff @(posedge clk) begin
    if (!rst_n)  armed <= 1'b0;
    else if (wr) armed <= (wdata == FIRST);
  end
endmodule

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  assign tick = src[sel];
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic             svc,
  input  logic [CNT_W-1:0] toval,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);
  logic expire, early;

  assign expire = en && tick && (cnt == toval);
  assign early  = en && svc && (win != '0) && (cnt < win);
  assign fire   = expire || early;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr || svc || expire)  cnt <= '0;
    else if (en && tick)            cnt <= cnt + 1'b1;
  end

  // count moves only by one step or back to zero
  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt == '0) || (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_W         = 16,
  parameter int UNLOCK_CYCLES = 128,
  localparam int TMR_W        = $clog2(UNLOCK_CYCLES + 1),
  localparam int N_SRC        = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_slow,
  input  logic        tick_mid,
  input  logic        tick_ext,
  output logic        rst_req
);
  import wdt_pkg::*;

  logic             unlocked, en_q, upd_q, rcs_q, flag_q, rst_req_q;
  src_e             sel_q;
  logic [TMR_W-1:0] ul_tmr;
  logic [CNT_W-1:0] toval_q, win_q, cnt;
  logic             cnt_wr, cs_wr, tov_wr, win_wr, apply;
  logic             open_hit, svc_hit, tick, fire;

  assign cnt_wr = bus_we && (bus_addr == OFS_CNT);
  assign cs_wr  = bus_we && (bus_addr == OFS_CS);
  assign tov_wr = bus_we && (bus_addr == OFS_TOV) && unlocked;
  assign win_wr = bus_we && (bus_addr == OFS_WIN) && unlocked;
  assign apply  = cs_wr && unlocked;

  wdt_key_match #(.FIRST(OPEN_W0), .SECOND(OPEN_W1)) u_open (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(bus_wdata), .hit(open_hit));

  wdt_key_match #(.FIRST(SVC_W0), .SECOND(SVC_W1)) u_svc (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(bus_wdata), .hit(svc_hit));

  wdt_tick_mux #(.N_SRC(N_SRC)) u_mux (
    .src({tick_ext, tick_mid, tick_slow, 1'b1}), .sel(sel_q), .tick(tick));

  wdt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .clr(apply), .svc(svc_hit),
    .toval(toval_q), .win(win_q), .cnt(cnt), .fire(fire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      ul_tmr    <= '0;
      en_q      <= 1'b0;
      upd_q     <= 1'b1;
      sel_q     <= SRC_BUS;
      rcs_q     <= 1'b0;
      flag_q    <= 1'b0;
      rst_req_q <= 1'b0;
      toval_q   <= '1;
      win_q     <= '0;
    end else begin
      rst_req_q <= fire;
      if (fire)                               flag_q <= 1'b1;
      else if (cs_wr && bus_wdata[B_FLG])     flag_q <= 1'b0;

      if (apply) begin
        en_q     <= bus_wdata[B_EN];
        upd_q    <= bus_wdata[B_UPD];
        sel_q    <= src_e'(bus_wdata[B_SEL +: 2]);
        rcs_q    <= 1'b1;
        unlocked <= 1'b0;
        ul_tmr   <= '0;
      end else if (open_hit && upd_q) begin
        unlocked <= 1'b1;
        ul_tmr   <= '0;
        rcs_q    <= 1'b0;
      end else if (unlocked) begin
        if (ul_tmr == TMR_W'(UNLOCK_CYCLES - 1)) unlocked <= 1'b0;
        else                                     ul_tmr   <= ul_tmr + 1'b1;
      end

      if (tov_wr) toval_q <= bus_wdata[CNT_W-1:0];
      if (win_wr) win_q   <= bus_wdata[CNT_W-1:0];
    end
  end

  assign rst_req = rst_req_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CS: begin
        bus_rdata[B_UPD]       = upd_q;
        bus_rdata[B_EN]        = en_q;
        bus_rdata[B_SEL +: 2]  = sel_q;
        bus_rdata[B_RCS]       = rcs_q;
        bus_rdata[B_ULK]       = unlocked;
        bus_rdata[B_FLG]       = flag_q;
      end
      OFS_CNT: bus_rdata[CNT_W-1:0] = cnt;
      OFS_TOV: bus_rdata[CNT_W-1:0] = toval_q;
      OFS_WIN: bus_rdata[CNT_W-1:0] = win_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_locked_tov_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_we && bus_addr == OFS_TOV) |=> $stable(toval_q));
  assert_open_needs_upd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> upd_q);
  assert_open_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (ul_tmr < TMR_W'(UNLOCK_CYCLES)));
  assert_open_clears_rcs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> !rcs_q);
  assert_req_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> flag_q);
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int UL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0, tick_mid = 1'b0, tick_ext = 1'b0;
  logic        rst_req;

  int total = 0, fails = 0, cyc = 0;
  int m = 0, tov = 0, win = 0, msel = 0;
  bit men = 0;
  int exp_q[$];

  keyed_wdt #(.CNT_W(16), .UNLOCK_CYCLES(UL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
    .tick_mid(tick_mid), .tick_ext(tick_ext), .rst_req(rst_req));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: each request pops the cycle the driver predicted
  always @(negedge clk) begin
    if (rst_n && rst_req === 1'b1) begin
      if (exp_q.size() == 0) chk("R7/R9 unexpected rst_req", 32'(cyc), 32'hFFFF_FFFF);
      else chk("R7/R9 rst_req cycle", 32'(cyc), 32'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_key();
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
  endtask

  task automatic slow_tick();
    if (men && msel == 1) begin
      if (m == tov) begin exp_q.push_back(cyc + 1); m = 0; end
      else m++;
    end
    tick_slow = 1'b1;
    @(negedge clk);
    tick_slow = 1'b0;
  endtask

  task automatic service();
    wr(4'h4, 32'hA602);
    if (men && win != 0 && m < win) exp_q.push_back(cyc + 1);
    m = 0;
    wr(4'h4, 32'hB480);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3); rst_n = 1'b1; idle(1);

    // R1 reset values
    rd(4'h0, d); chk("R1 CS", d, 32'h20);
    rd(4'h4, d); chk("R1 CNT", d, 0);
    rd(4'h8, d); chk("R1 TOVAL", d, 32'hFFFF);
    rd(4'hC, d); chk("R1 WIN", d, 0);
    chk("R1 rst_req", 32'(rst_req), 0);

    // R3 locked writes ignored
    wr(4'h8, 32'h5); wr(4'hC, 32'h9); wr(4'h0, 32'h1A0);
    rd(4'h8, d); chk("R3 TOVAL locked", d, 32'hFFFF);
    rd(4'hC, d); chk("R3 WIN locked", d, 0);
    rd(4'h0, d); chk("R3 CS locked", d, 32'h20);

    // R2 broken and restarted keys
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234); wr(4'h4, 32'hD928);
    rd(4'h0, d); chk("R2 broken key", d[11], 0);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    rd(4'h0, d); chk("R2 restart key", d, 32'h820);

    // R4 apply configuration, source 1, timeout 3
    wr(4'h8, 32'h3); wr(4'hC, 32'h0); wr(4'h0, 32'h41A0);
    tov = 3; win = 0; men = 1; msel = 1; m = 0;
    rd(4'h0, d); chk("R4 applied status", d, 32'h5A0);
    rd(4'h8, d); chk("R4 TOVAL written", d, 3);

    // R7 timeout on the fourth tick
    repeat (4) slow_tick();
    idle(1);
    rd(4'h0, d); chk("R7 flag set", d, 32'h45A0);
    rd(4'h4, d); chk("R7 count restart", d, 0);
    // R10 flag clear while locked
    wr(4'h0, 32'h4000);
    rd(4'h0, d); chk("R10 flag cleared", d, 32'h5A0);

    // R6 source selection
    repeat (2) slow_tick();
    rd(4'h4, d); chk("R6 selected ticks", d, 2);
    tick_mid = 1'b1; tick_ext = 1'b1; idle(1); tick_mid = 1'b0; tick_ext = 1'b0;
    rd(4'h4, d); chk("R6 other sources ignored", d, 2);

    // R8 service
    service();
    rd(4'h4, d); chk("R8 service clears", d, 0);
    repeat (2) slow_tick();
    wr(4'h4, 32'hA602); wr(4'h4, 32'h0); wr(4'h4, 32'hB480);
    rd(4'h4, d); chk("R8 broken service", d, 2);

    // R9 window of 2
    open_key();
    wr(4'hC, 32'h2); wr(4'h0, 32'h1A0);
    win = 2; m = 0;
    slow_tick();
    service();
    idle(1);
    rd(4'h0, d); chk("R9 early service flag", d, 32'h45A0);
    rd(4'h4, d); chk("R9 count after service", d, 0);
    repeat (3) slow_tick();
    service();
    idle(1);
    rd(4'h4, d); chk("R9 late service ok", d, 0);

    // R4 unlock expires by itself
    open_key();
    rd(4'h0, d); chk("R4 unlocked", d[11], 1);
    rd(4'h0, d); chk("R4 unlock clears applied", d[10], 0);
    idle(UL + 4);
    rd(4'h0, d); chk("R4 unlock expired", d[11], 0);
    wr(4'h8, 32'h7);
    rd(4'h8, d); chk("R3 TOVAL after expiry", d, 3);

    // R6 bus-clock source: period TOVAL+1
    open_key();
    wr(4'h8, 32'h4);
    msel = 0;
    exp_q.push_back(cyc + 1 + 5);
    exp_q.push_back(cyc + 1 + 10);
    wr(4'h0, 32'hA0);
    idle(10);
    open_key();
    wr(4'h0, 32'h4100);
    men = 0;
    rd(4'h0, d); chk("R4 final config", d, 32'h500);

    // R5 re-unlock refused
    open_key();
    rd(4'h0, d); chk("R5 unlock refused", d[11], 0);
    wr(4'h8, 32'h9);
    rd(4'h8, d); chk("R5 TOVAL stays", d, 4);

    idle(20);
    chk("R7 all expected requests seen", 32'(exp_q.size()), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule